// File: doc/BRIEF.md
# Dock Instruction Queue with Control Operations

This block feeds instructions, one at a time, to the execution logic of a dock. Instructions arrive over a valid/ready handshake into a single-entry intake stage. From there they move into a circular buffer of parameter depth, and from the buffer head into an on-deck register. The on-deck register is what the execution logic sees. When the execution logic reports that the on-deck instruction must run again, the block writes that instruction back to the buffer tail. Order is therefore kept as a rotating ring.

Four control words act on the queue contents instead of executing. A hold-up word travels through the buffer and parks on deck, blocking execution until a matching release word arrives. A skip word and a flush word both wait in the intake stage until the on-deck instruction is marked as interruptible. The skip word then discards that one instruction, which may still go around the ring again. The flush word discards everything queued. A release word with no hold-up anywhere in the queue blocks intake for good, until reset.

Top module: `dock_instr_queue`

## Requirements
- R1: After reset the on-deck register and the buffer are empty: `od_valid` is 0, `in_ready` is 1, and no event strobe (`exec_go`, `skip_go`, `purge_go`, `release_go`) or `rl_valid` is raised.
- R2: Ordinary instructions reach the on-deck register and execute in the order they were accepted. A word is a control word when bits 21:19 are 000 and bit 18 is 1; every other word is ordinary. `exec_go` is only raised while `od_valid` is 1.
- R3: An ordinary on-deck instruction executes only in a cycle where both `ds_empty` and `ts_empty` are 1.
- R4: When an on-deck instruction executes or is skipped while `loop_more` is 1, `rl_valid` is 1 in that cycle with `rl_instr` equal to `od_instr`. The instruction re-enters the buffer behind the instructions already queued. With `loop_more` at 0 it retires.
- R5: An instruction that will go around again needs a free buffer slot. While the buffer is full and `loop_more` is 1, nothing executes. With `loop_more` at 0, the on-deck instruction executes even when the buffer is full.
- R6: The block holds at most DEPTH+2 instructions (on deck, DEPTH in the buffer, one in intake). `in_ready` is 0 while the intake stage is occupied and cannot move on.
- R7: A hold-up word (control, bits 17:16 = 10) passes through the buffer, stays on deck unchanged, and nothing executes while it is there.
- R8: A release word (control, bits 17:16 = 11) waits in intake until a hold-up word is on deck. It then raises `release_go` for one cycle, both words retire, and queued instructions resume.
- R9: A skip word (control, bits 17:16 = 00) waits in intake until the on-deck instruction is ordinary with bit 25 set. It then raises `skip_go` in place of `exec_go`. An ordinary instruction with bit 25 clear is never skipped. A waiting skip word takes precedence over execution in the same cycle.
- R10: A flush word (control, bits 17:16 = 01) waits in intake until the on-deck instruction is ordinary with bit 25 set. It then raises `purge_go`, and in the next cycle the on-deck register and the whole buffer are empty.
- R11: A release word accepted while no hold-up word is on deck or queued stalls the block permanently: `in_ready` stays 0 and no event strobe fires until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming instruction is valid |
| in_instr | input | 26 | Incoming instruction word |
| in_ready | output | 1 | Intake stage can accept a word this cycle |
| ds_empty | input | 1 | Data successor stage is empty |
| ts_empty | input | 1 | Token successor stage is empty |
| loop_more | input | 1 | On-deck instruction must go around the ring again when it completes |
| od_valid | output | 1 | On-deck register holds an instruction |
| od_instr | output | 26 | On-deck instruction word |
| exec_go | output | 1 | On-deck instruction executes this cycle |
| skip_go | output | 1 | On-deck instruction is skipped by a skip word this cycle |
| purge_go | output | 1 | Flush word discards on-deck and buffered instructions this cycle |
| release_go | output | 1 | Release word and on-deck hold-up word retire this cycle |
| rl_valid | output | 1 | Write-back of the on-deck instruction to the buffer tail this cycle |
| rl_instr | output | 26 | Word written back to the buffer tail |

## Verification
A bad buffer pointer or count shows up at the ports within a few cycles. An instruction reaches `exec_go` out of order, appears twice or never appears, and the scoreboard compares every event strobe against the expected word. A wrong control-word decision shows up as a strobe of the wrong kind, or as a missing one. Examples are a skip on an instruction with bit 25 clear, or a release fired with nothing held on deck. The scoreboard sees this in the very cycle the on-deck register would have moved. A lost free-slot check shows up as execution while the buffer is full with `loop_more` set, and this is held for several cycles to make it visible.

// File: rtl/diq_pkg.sv
package diq_pkg;

  localparam int INSTR_W = 26;
  localparam int IM_BIT  = 25;

  typedef enum logic [1:0] {
    CT_SKIP    = 2'b00,
    CT_FLUSH   = 2'b01,
    CT_HOLD    = 2'b10,
    CT_RELEASE = 2'b11
  } ctl_op_e;

  typedef logic [INSTR_W-1:0] instr_t;

  // control words: bits 21:19 zero and bit 18 set
  function automatic logic is_ctl(input instr_t w);
    return (w[21:19] == 3'b000) && w[18];
  endfunction

  function automatic ctl_op_e ctl_op(input instr_t w);
    return ctl_op_e'(w[17:16]);
  endfunction

  function automatic logic is_im(input instr_t w);
    return w[IM_BIT];
  endfunction

  function automatic logic is_hold(input instr_t w);
    return is_ctl(w) && (ctl_op(w) == CT_HOLD);
  endfunction

  // words that wait in the intake stage instead of entering the ring
  function automatic logic is_parked(input instr_t w);
    return is_ctl(w) && (ctl_op(w) != CT_HOLD);
  endfunction

endpackage

// File: rtl/diq_hold.sv
module diq_hold
  import diq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   in_valid,
  input  instr_t in_instr,
  output logic   in_ready,
  input  logic   take,
  output logic   h_valid,
  output instr_t h_instr
);

  // ready does not look at in_valid, so no combinational loop at the edge
  assign in_ready = !h_valid || take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_valid <= 1'b0;
      h_instr <= '0;
    end else if (in_valid && in_ready) begin
      h_valid <= 1'b1;
      h_instr <= in_instr;
    end else if (take) begin
      h_valid <= 1'b0;
    end
  end

  assert_take_needs_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> h_valid);

endmodule

// File: rtl/diq_ring.sv
module diq_ring
  import diq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_en,
  input  instr_t wr_data,
  input  logic   rd_en,
  input  logic   clear,
  output instr_t head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic   full,
  output logic   empty
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
  endfunction

  instr_t         slot [DEPTH];
  logic [PW-1:0]  wr_ptr, rd_ptr;
  logic [DEPTH-1:0] slot_we;

  for (genvar g = 0; g < DEPTH; g++) begin : g_we
    assign slot_we[g] = wr_en && (wr_ptr == PW'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (slot_we[i]) slot[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= step_ptr(wr_ptr);
      if (rd_en) rd_ptr <= step_ptr(rd_ptr);
      count <= count + CW'(wr_en) - CW'(rd_en);
    end
  end

  assign head  = slot[rd_ptr];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  assert_ring_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);
  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty);

endmodule

// File: rtl/diq_arbiter.sv
module diq_arbiter
  import diq_pkg::*;
(
  input  logic   h_valid,
  input  instr_t h_instr,
  input  logic   od_valid,
  input  instr_t od_instr,
  input  logic   ring_full,
  input  logic   ring_empty,
  input  logic   ds_empty,
  input  logic   ts_empty,
  input  logic   loop_more,
  output logic   exec_go,
  output logic   skip_go,
  output logic   purge_go,
  output logic   release_go,
  output logic   od_leave,
  output logic   rl_wr,
  output logic   h_push,
  output logic   h_take,
  output logic   ring_pop
);

  logic    h_parked, od_plain, od_hold, od_target, slot_ok;
  ctl_op_e h_op;

  assign h_op      = ctl_op(h_instr);
  assign h_parked  = h_valid && is_parked(h_instr);
  assign od_plain  = od_valid && !is_ctl(od_instr);
  assign od_hold   = od_valid && is_hold(od_instr);
  assign od_target = od_plain && is_im(od_instr);
  // a write-back needs a free tail slot; a retiring instruction does not
  assign slot_ok   = !ring_full || !loop_more;

  assign skip_go    = h_parked && (h_op == CT_SKIP) && od_target && slot_ok;
  assign purge_go   = h_parked && (h_op == CT_FLUSH) && od_target;
  assign release_go = h_parked && (h_op == CT_RELEASE) && od_hold;

  assign exec_go = od_plain && ds_empty && ts_empty && slot_ok
                   && !skip_go && !purge_go;

  assign rl_wr    = (exec_go || skip_go) && loop_more;
  assign od_leave = exec_go || skip_go || purge_go || release_go;
  assign h_push   = h_valid && !h_parked && !ring_full && !rl_wr;
  assign h_take   = h_push || skip_go || purge_go || release_go;
  assign ring_pop = !ring_empty && (!od_valid || od_leave) && !purge_go;

endmodule

// File: rtl/dock_instr_queue.sv
module dock_instr_queue
  import diq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] in_instr,
  output logic               in_ready,
  input  logic               ds_empty,
  input  logic               ts_empty,
  input  logic               loop_more,
  output logic               od_valid,
  output logic [INSTR_W-1:0] od_instr,
  output logic               exec_go,
  output logic               skip_go,
  output logic               purge_go,
  output logic               release_go,
  output logic               rl_valid,
  output logic [INSTR_W-1:0] rl_instr
);

  localparam int CW = $clog2(DEPTH+1);

  logic   h_valid, h_take, h_push, od_leave, rl_wr, ring_pop;
  logic   ring_full, ring_empty;
  instr_t h_instr, ring_head;
  logic [CW-1:0] ring_count;

  diq_hold u_hold (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_instr(in_instr), .in_ready(in_ready),
    .take(h_take), .h_valid(h_valid), .h_instr(h_instr)
  );

  diq_ring #(.DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .wr_en(rl_wr || h_push),
    .wr_data(rl_wr ? od_instr : h_instr),
    .rd_en(ring_pop), .clear(purge_go),
    .head(ring_head), .count(ring_count),
    .full(ring_full), .empty(ring_empty)
  );

  diq_arbiter u_arb (
    .h_valid(h_valid), .h_instr(h_instr),
    .od_valid(od_valid), .od_instr(od_instr),
    .ring_full(ring_full), .ring_empty(ring_empty),
    .ds_empty(ds_empty), .ts_empty(ts_empty), .loop_more(loop_more),
    .exec_go(exec_go), .skip_go(skip_go), .purge_go(purge_go),
    .release_go(release_go), .od_leave(od_leave), .rl_wr(rl_wr),
    .h_push(h_push), .h_take(h_take), .ring_pop(ring_pop)
  );

  // on-deck register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      od_valid <= 1'b0;
      od_instr <= '0;
    end else if (ring_pop) begin
      od_valid <= 1'b1;
      od_instr <= ring_head;
    end else if (od_leave) begin
      od_valid <= 1'b0;
    end
  end

  assign rl_valid = rl_wr;
  assign rl_instr = od_instr;

  assert_go_on_deck_R2: assert property (@(posedge clk) disable iff (!rst_n)
    exec_go |-> od_valid && !is_ctl(od_instr));
  assert_successors_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exec_go |-> ds_empty && ts_empty);
  assert_writeback_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rl_valid |-> loop_more && (exec_go || skip_go));
  assert_full_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_count == CW'(DEPTH)) && loop_more |-> !exec_go && !skip_go);
  assert_hold_sticks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    od_valid && is_hold(od_instr) && !release_go |=> od_valid && $stable(od_instr));
  assert_release_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    release_go |-> od_valid && is_hold(od_instr) && h_valid);
  assert_one_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({exec_go, skip_go, purge_go, release_go}));
  assert_skip_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    skip_go |-> is_im(od_instr));
  assert_purge_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    purge_go |=> !od_valid && (ring_count == '0));

endmodule

// File: tb/sim_dock_instr_queue.sv
`timescale 1ns/100ps
module sim_dock_instr_queue;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [25:0] in_instr = '0;
  logic        ds_empty = 1'b1, ts_empty = 1'b1, loop_more = 1'b0;
  logic        in_ready, od_valid, exec_go, skip_go, purge_go, release_go, rl_valid;
  logic [25:0] od_instr, rl_instr;

  int checks = 0;
  int fails  = 0;

  // event kinds: 0 execute, 1 skip, 2 flush, 3 release
  int          exp_kind [$];
  logic [25:0] exp_word [$];
  string       exp_req  [$];

  always #2 clk = ~clk;

  dock_instr_queue #(.DEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
    .in_ready(in_ready), .ds_empty(ds_empty), .ts_empty(ts_empty),
    .loop_more(loop_more), .od_valid(od_valid), .od_instr(od_instr),
    .exec_go(exec_go), .skip_go(skip_go), .purge_go(purge_go),
    .release_go(release_go), .rl_valid(rl_valid), .rl_instr(rl_instr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [25:0] mk_norm(input logic im, input logic [18:0] tag);
    return {im, 3'b011, 3'b001, tag};
  endfunction

  function automatic logic [25:0] mk_ctl(input logic [1:0] op);
    return {4'b0000, 3'b000, 1'b1, op, 16'h0000};
  endfunction

  task automatic expect_ev(input int k, input logic [25:0] w, input string req);
    exp_kind.push_back(k);
    exp_word.push_back(w);
    exp_req.push_back(req);
  endtask

  task automatic send(input logic [25:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_instr = w;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 300 && exp_kind.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(exp_kind.size() == 0, tag, exp_kind.size(), 0);
  endtask

  task automatic step_exec();
    @(negedge clk); ds_empty = 1'b1;
    @(negedge clk); ds_empty = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // scoreboard monitor, sampled half a nanosecond before the rising edge
  int          ev_kind;
  int          e_k;
  logic [25:0] e_w;
  string       e_r;
  always @(negedge clk) begin
    #1.5;
    if (rst_n && (exec_go || skip_go || purge_go || release_go)) begin
      ev_kind = exec_go ? 0 : skip_go ? 1 : purge_go ? 2 : 3;
      if (exp_kind.size() == 0) begin
        chk(1'b0, "R2 unexpected event", ev_kind, 32'hffff_ffff);
      end else begin
        e_k = exp_kind.pop_front();
        e_w = exp_word.pop_front();
        e_r = exp_req.pop_front();
        chk(ev_kind == e_k, {e_r, " event kind"}, ev_kind, e_k);
        chk(od_valid && od_instr == e_w, {e_r, " on-deck word"}, od_instr, e_w);
      end
      if ((exec_go || skip_go) && loop_more)
        chk(rl_valid && rl_instr == od_instr, "R4 write-back", rl_instr, od_instr);
      if ((exec_go || skip_go) && !loop_more)
        chk(!rl_valid, "R4 retire without write-back", rl_valid, 0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(!od_valid, "R1 od_valid after reset", od_valid, 0);
    chk(in_ready, "R1 in_ready after reset", in_ready, 1);
    chk(!(exec_go || skip_go || purge_go || release_go || rl_valid), "R1 strobes idle",
        {exec_go, skip_go, purge_go, release_go, rl_valid}, 0);

    // R2 order of execution
    for (int i = 1; i <= 3; i++) expect_ev(0, mk_norm(1'b0, 19'(16'h100 + i)), "R2");
    for (int i = 1; i <= 3; i++) send(mk_norm(1'b0, 19'(16'h100 + i)));
    drain("R2 drained");
    chk(!od_valid, "R2 deck empty when idle", od_valid, 0);

    // R3 successor gating
    ds_empty = 1'b0;
    send(mk_norm(1'b0, 19'h200));
    repeat (6) @(negedge clk); #1;
    chk(od_valid && od_instr == mk_norm(1'b0, 19'h200), "R3 waits for data successor", od_instr, mk_norm(1'b0, 19'h200));
    @(negedge clk); ds_empty = 1'b1; ts_empty = 1'b0;
    repeat (4) @(negedge clk); #1;
    chk(od_valid, "R3 waits for token successor", od_valid, 1);
    expect_ev(0, mk_norm(1'b0, 19'h200), "R3");
    @(negedge clk); ts_empty = 1'b1;
    drain("R3 drained");

    // R7 hold-up word parks on deck, R8 release word frees it
    send(mk_ctl(2'b10));
    send(mk_norm(1'b0, 19'h300));
    repeat (8) @(negedge clk); #1;
    chk(od_valid && od_instr == mk_ctl(2'b10), "R7 hold-up parked on deck", od_instr, mk_ctl(2'b10));
    expect_ev(3, mk_ctl(2'b10), "R8");
    expect_ev(0, mk_norm(1'b0, 19'h300), "R8");
    send(mk_ctl(2'b11));
    drain("R8 drained");

    // R9 skip word: non-marked instruction runs, marked one is skipped
    @(negedge clk); ds_empty = 1'b0;
    send(mk_norm(1'b0, 19'h400));
    send(mk_norm(1'b1, 19'h401));
    send(mk_ctl(2'b00));
    repeat (6) @(negedge clk); #1;
    chk(od_instr == mk_norm(1'b0, 19'h400), "R9 unmarked not skipped", od_instr, mk_norm(1'b0, 19'h400));
    expect_ev(0, mk_norm(1'b0, 19'h400), "R9");
    expect_ev(1, mk_norm(1'b1, 19'h401), "R9");
    @(negedge clk); ds_empty = 1'b1;
    drain("R9 drained");

    // R4 ring rotation with write-back
    @(negedge clk); ds_empty = 1'b0; loop_more = 1'b1;
    send(mk_norm(1'b1, 19'h500));
    send(mk_norm(1'b1, 19'h501));
    repeat (4) @(negedge clk);
    expect_ev(0, mk_norm(1'b1, 19'h500), "R4");
    expect_ev(0, mk_norm(1'b1, 19'h501), "R4");
    expect_ev(0, mk_norm(1'b1, 19'h500), "R4");
    repeat (3) step_exec();
    #1;
    chk(od_instr == mk_norm(1'b1, 19'h501), "R4 rotated order", od_instr, mk_norm(1'b1, 19'h501));
    @(negedge clk); loop_more = 1'b0;
    expect_ev(0, mk_norm(1'b1, 19'h501), "R4");
    expect_ev(0, mk_norm(1'b1, 19'h500), "R4");
    repeat (2) step_exec();
    #1;
    chk(!od_valid, "R4 retired", od_valid, 0);
    drain("R4 drained");

    // R5 / R6 full buffer
    @(negedge clk); ds_empty = 1'b0; loop_more = 1'b1;
    for (int i = 0; i < 6; i++) send(mk_norm(1'b0, 19'(16'h600 + i)));
    #1;
    chk(!in_ready, "R6 intake blocked at capacity", in_ready, 0);
    @(negedge clk); ds_empty = 1'b1;
    repeat (5) @(negedge clk); #1;
    chk(od_instr == mk_norm(1'b0, 19'h600), "R5 no execution into full buffer", od_instr, mk_norm(1'b0, 19'h600));
    for (int i = 0; i < 6; i++) expect_ev(0, mk_norm(1'b0, 19'(16'h600 + i)), "R5");
    @(negedge clk); loop_more = 1'b0;
    drain("R5 drained");

    // R10 flush word
    @(negedge clk); ds_empty = 1'b0;
    for (int i = 0; i < 3; i++) send(mk_norm(1'b1, 19'(16'h700 + i)));
    expect_ev(2, mk_norm(1'b1, 19'h700), "R10");
    send(mk_ctl(2'b01));
    drain("R10 drained");
    #1;
    chk(!od_valid, "R10 deck empty after flush", od_valid, 0);
    @(negedge clk); ds_empty = 1'b1;
    repeat (6) @(negedge clk); #1;
    chk(!od_valid, "R10 buffer empty after flush", od_valid, 0);

    // R11 release word with nothing held
    send(mk_ctl(2'b11));
    @(negedge clk); in_valid = 1'b1; in_instr = mk_norm(1'b0, 19'h7ff);
    repeat (20) @(negedge clk); #1;
    chk(!in_ready, "R11 permanent stall", in_ready, 0);
    chk(!od_valid, "R11 nothing reaches deck", od_valid, 0);
    @(negedge clk); in_valid = 1'b0;

    // R1 reset recovers the block
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(in_ready, "R1 in_ready after second reset", in_ready, 1);
    expect_ev(0, mk_norm(1'b0, 19'h050), "R1");
    send(mk_norm(1'b0, 19'h050));
    drain("R1 drained after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule